// File: doc/BRIEF.md
# Backplane Link Turnaround Controller

This block decides which of a module's two backplane differential pairs (the data pair and the clock pair) its transceivers drive, and when they drive them. In the half-duplex link mode, the unit that sends data also supplies the clock. Both transceivers therefore turn around together under the processor's active-low transmit enable. In the full-duplex mode, the clock pair becomes the module's outgoing line and the data pair stays an incoming line.

Transmission starts when the transmit enable falls. It stops when the serial controller strobes that the final character has left, when the enable is released, or when the active-low fail-safe is asserted. After any of these, the drivers stay off until the enable falls again. Fail-safe also gates every driver off in the same cycle it appears. The mode select only takes effect while nothing is being sent, so the roles of the pairs never change during a frame.

The block also produces an active-low transmitter-active flag for an open-collector output, where 0 means pulled low. It raises a hardware-reset request when the select and reset lines are both high. Its presence output mirrors the select line.

Top module: `lineDirCtl`

## Requirements
- R1: While `rstN` is low and after its release, both driver enables are 0, `txActiveN` is 1 and the link mode is half duplex. A fall of `txEnN` after reset then drives both pairs.
- R2: In half-duplex mode, a 1-to-0 change of `txEnN` sampled at a clock edge sets `dataDrvEn` and `clkDrvEn` to 1 after that edge, provided `failSafeN` is 1 and `lastCharDone` is 0.
- R3: In half-duplex mode, `failSafeN` = 0 forces `dataDrvEn` and `clkDrvEn` to 0 in the same cycle. Transmission then stays off after `failSafeN` returns to 1, until `txEnN` falls again.
- R4: In full-duplex mode (`asyncSel` = 1 loaded while idle), an armed transmitter drives only the clock pair: `clkDrvEn` = 1 and `dataDrvEn` = 0.
- R5: In full-duplex mode, `failSafeN` = 0 forces `clkDrvEn` to 0 in the same cycle and disarms the transmitter.
- R6: `lastCharDone` = 1 at an edge turns off all drivers after that edge, even if `txEnN` stays low, and even if it coincides with a fall of `txEnN`. A held-low `txEnN` does not re-arm the transmitter.
- R7: `txEnN` = 1 at an edge turns off all drivers after that edge.
- R8: `txActiveN` is 0 exactly when a pair driver is enabled, and 1 otherwise.
- R9: `hwResetReq` is 1 exactly when `selectIn` and `resetIn` are both 1.
- R10: `present` equals `selectIn`.
- R11: A change of `asyncSel` while the transmitter is armed has no effect on which pairs are driven. The new mode is loaded at the first edge at which the transmitter is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rstN | input | 1 | Asynchronous active-low reset |
| txEnN | input | 1 | Processor transmit enable, active low |
| asyncSel | input | 1 | Link mode select: 1 = full duplex, 0 = half duplex |
| failSafeN | input | 1 | Fail-safe, active low |
| selectIn | input | 1 | Backplane select line, active high |
| resetIn | input | 1 | Backplane reset line, active high |
| lastCharDone | input | 1 | One-cycle strobe: final character sent |
| dataDrvEn | output | 1 | Data pair driver enable |
| clkDrvEn | output | 1 | Clock pair driver enable |
| txActiveN | output | 1 | Transmitter-active flag for open-collector output, 0 = active |
| hwResetReq | output | 1 | Hardware reset request |
| present | output | 1 | Presence indication |

## Verification
The vector walk runs both link modes with the same arm-and-stop patterns. The data pair must follow the clock pair in half duplex and stay quiet in full duplex, which separates a correct mode decode from a swapped or ignored one. It raises `asyncSel` mid-frame and then lets the frame end, which separates a mode that is loaded only when idle from one that is loaded unconditionally. Fail-safe, end-of-frame strobes and enable releases are each followed by an idle vector with `txEnN` still low, which separates a one-shot arm from a level-sensitive one. Directed cases cover reset with the enable low, a fail-safe drop observed between edges, and an end-of-frame strobe that lands on the same edge as a new enable fall.

// File: rtl/lineDirPkg.sv
package lineDirPkg;

  typedef enum logic {
    MODE_HALF = 1'b0,
    MODE_FULL = 1'b1
  } linkModeT;

  typedef struct packed {
    logic armSet;
    logic armClr;
    logic modeLoad;
  } dirStrobeT;

endpackage

// File: rtl/lineDirCtrl.sv
module lineDirCtrl
  import lineDirPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  logic      txEnN,
  input  logic      failSafeN,
  input  logic      lastCharDone,
  input  logic      armed,
  output dirStrobeT strobe
);

  logic prevTxEnN;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevTxEnN <= 1'b1;
    else       prevTxEnN <= txEnN;
  end

  always_comb begin
    strobe.armSet   = prevTxEnN && !txEnN;
    strobe.armClr   = !failSafeN || lastCharDone || txEnN;
    strobe.modeLoad = !armed;
  end

endmodule

// File: rtl/lineDirPath.sv
module lineDirPath
  import lineDirPkg::*;
(
  input  logic      clk,
  input  logic      rstN,
  input  dirStrobeT strobe,
  input  logic      asyncSel,
  input  logic      failSafeN,
  input  logic      selectIn,
  input  logic      resetIn,
  output logic      armed,
  output logic      dataDrvEn,
  output logic      clkDrvEn,
  output logic      txActiveN,
  output logic      hwResetReq,
  output logic      present
);

  linkModeT linkMode;
  logic     txOn;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              armed <= 1'b0;
    else if (strobe.armClr) armed <= 1'b0;
    else if (strobe.armSet) armed <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                linkMode <= MODE_HALF;
    else if (strobe.modeLoad) linkMode <= asyncSel ? MODE_FULL : MODE_HALF;
  end

  // fail-safe gates the drivers combinationally, ahead of the next edge
  assign txOn       = armed && failSafeN;
  assign clkDrvEn   = txOn;
  assign dataDrvEn  = txOn && (linkMode == MODE_HALF);
  assign txActiveN  = !txOn;
  assign hwResetReq = selectIn && resetIn;
  assign present    = selectIn;

endmodule

// File: rtl/lineDirCtl.sv
module lineDirCtl
  import lineDirPkg::*;
(
  input  logic clk,
  input  logic rstN,
  input  logic txEnN,
  input  logic asyncSel,
  input  logic failSafeN,
  input  logic selectIn,
  input  logic resetIn,
  input  logic lastCharDone,
  output logic dataDrvEn,
  output logic clkDrvEn,
  output logic txActiveN,
  output logic hwResetReq,
  output logic present
);

  dirStrobeT strobe;
  logic      armed;

  lineDirCtrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .txEnN        (txEnN),
    .failSafeN    (failSafeN),
    .lastCharDone (lastCharDone),
    .armed        (armed),
    .strobe       (strobe)
  );

  lineDirPath u_path (
    .clk        (clk),
    .rstN       (rstN),
    .strobe     (strobe),
    .asyncSel   (asyncSel),
    .failSafeN  (failSafeN),
    .selectIn   (selectIn),
    .resetIn    (resetIn),
    .armed      (armed),
    .dataDrvEn  (dataDrvEn),
    .clkDrvEn   (clkDrvEn),
    .txActiveN  (txActiveN),
    .hwResetReq (hwResetReq),
    .present    (present)
  );

endmodule

// File: rtl/lineDirCheck.sv
module lineDirCheck (
  input logic clk,
  input logic rstN,
  input logic txEnN,
  input logic failSafeN,
  input logic lastCharDone,
  input logic dataDrvEn,
  input logic clkDrvEn
);

  assert_failsafe_half_R3: assert property (@(posedge clk) disable iff (!rstN)
    !failSafeN |-> !dataDrvEn);

  assert_failsafe_full_R5: assert property (@(posedge clk) disable iff (!rstN)
    !failSafeN |-> !clkDrvEn);

  assert_last_char_off_R6: assert property (@(posedge clk) disable iff (!rstN)
    lastCharDone |=> !clkDrvEn && !dataDrvEn);

  assert_release_off_R7: assert property (@(posedge clk) disable iff (!rstN)
    txEnN |=> !clkDrvEn && !dataDrvEn);

  assert_data_needs_clk_R4: assert property (@(posedge clk) disable iff (!rstN)
    dataDrvEn |-> clkDrvEn);

  assert_arm_on_fall_R2: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(txEnN) && failSafeN && !lastCharDone) |=> (clkDrvEn || !failSafeN));

endmodule

bind lineDirCtl lineDirCheck u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .txEnN        (txEnN),
  .failSafeN    (failSafeN),
  .lastCharDone (lastCharDone),
  .dataDrvEn    (dataDrvEn),
  .clkDrvEn     (clkDrvEn)
);

// File: tb/tb_lineDirCtl.sv
module tb_lineDirCtl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_VEC    = 16;

  // {txEnN, asyncSel, failSafeN, selectIn, resetIn, lastCharDone,
  //  expData, expClk, expTxActN, expHwRst, expPresent}
  localparam logic [10:0] VEC [NUM_VEC] = '{
    11'b1_0_1_0_0_0__0_0_1_0_0, // idle
    11'b0_0_1_0_0_0__1_1_0_0_0, // R2 fall arms both pairs
    11'b0_1_1_1_0_0__1_1_0_0_1, // R11 mode change ignored, R10
    11'b0_1_1_1_1_1__0_0_1_1_1, // R6 last char, R9
    11'b0_1_1_0_1_0__0_0_1_0_0, // R6 no re-arm, mode loads
    11'b1_1_1_0_0_0__0_0_1_0_0, // idle, full duplex
    11'b0_1_1_0_0_0__0_1_0_0_0, // R4 clock pair only
    11'b0_0_0_0_0_0__0_0_1_0_0, // R5 fail-safe
    11'b0_0_1_0_0_0__0_0_1_0_0, // R5 stays off after release
    11'b1_0_1_0_0_0__0_0_1_0_0, // idle, half duplex again
    11'b0_0_1_0_0_0__1_1_0_0_0, // R2
    11'b0_0_0_0_0_0__0_0_1_0_0, // R3 fail-safe
    11'b1_0_1_0_0_0__0_0_1_0_0, // R3 stays off
    11'b0_0_1_0_0_0__1_1_0_0_0, // R2 re-arm
    11'b1_0_1_0_0_0__0_0_1_0_0, // R7 release
    11'b0_1_1_1_1_0__0_1_0_1_1  // R4 mode loaded at arming edge, R9
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic txEnN = 1'b0;
  logic asyncSel = 1'b0;
  logic failSafeN = 1'b1;
  logic selectIn = 1'b0;
  logic resetIn = 1'b0;
  logic lastCharDone = 1'b0;
  logic dataDrvEn, clkDrvEn, txActiveN, hwResetReq, present;

  int numChecks = 0;
  int numFails  = 0;
  bit finished  = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  lineDirCtl dut (
    .clk          (clk),
    .rstN         (rstN),
    .txEnN        (txEnN),
    .asyncSel     (asyncSel),
    .failSafeN    (failSafeN),
    .selectIn     (selectIn),
    .resetIn      (resetIn),
    .lastCharDone (lastCharDone),
    .dataDrvEn    (dataDrvEn),
    .clkDrvEn     (clkDrvEn),
    .txActiveN    (txActiveN),
    .hwResetReq   (hwResetReq),
    .present      (present)
  );

  task automatic check(input string tag, input logic [4:0] act, input logic [4:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: outputs act=%b exp=%b (data,clk,txActN,hwRst,present)", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outs();
    return {dataDrvEn, clkDrvEn, txActiveN, hwResetReq, present};
  endfunction

  task automatic drive(input logic [5:0] v);
    {txEnN, asyncSel, failSafeN, selectIn, resetIn, lastCharDone} = v;
  endtask

  task automatic stepCheck(input string tag, input logic [5:0] v, input logic [4:0] exp);
    @(negedge clk);
    drive(v);
    @(posedge clk);
    #1;
    check(tag, outs(), exp);
  endtask

  initial begin
    #(CLK_PERIOD * 5000);
    if (!finished) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
      $finish;
    end
  end

  initial begin
    // R1: reset state with enable held low
    repeat (3) @(negedge clk);
    check("R1 in reset", outs(), 5'b00100);
    txEnN = 1'b1;
    @(negedge clk);
    rstN = 1'b1;
    @(posedge clk);
    #1;
    check("R1 after release", outs(), 5'b00100);

    for (int i = 0; i < NUM_VEC; i++) begin
      stepCheck($sformatf("vector %0d", i), VEC[i][10:5], VEC[i][4:0]);
    end

    // R1: mode after a fresh reset is half duplex
    @(negedge clk);
    rstN = 1'b0;
    drive(6'b1_1_1_0_0_0);
    @(negedge clk);
    rstN = 1'b1;
    asyncSel = 1'b0;
    stepCheck("R1 half duplex after reset", 6'b0_0_1_0_0_0, 5'b11000);

    // R3: fail-safe acts between edges
    @(negedge clk);
    failSafeN = 1'b0;
    #1;
    check("R3 same-cycle fail-safe", outs(), 5'b00100);
    failSafeN = 1'b1;

    // R6: last-char strobe on the same edge as a new fall
    stepCheck("R6 idle", 6'b1_0_1_0_0_0, 5'b00100);
    stepCheck("R6 strobe beats fall", 6'b0_0_1_0_0_1, 5'b00100);
    stepCheck("R6 held low no arm", 6'b0_0_1_0_0_0, 5'b00100);

    // R8 and R10: flag and presence in full duplex
    stepCheck("R8 idle", 6'b1_1_1_1_0_0, 5'b00101);
    stepCheck("R8 full duplex arm", 6'b0_1_1_1_0_0, 5'b01001);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", numChecks, numFails);
    $finish;
  end

endmodule